// File: doc/BRIEF.md
# Power-Good Startup Sequencer

This block brings a clock generator out of power-up in a fixed order. While the supply-valid reset is low, the block holds its state. Once that reset is released, the block steps from an off state into a wait state. It stays there until the active-low power-good input asserts.

On the clock edge where power-good is first seen, the block captures the three frequency-select pins into a held code. It then counts a fixed dwell of about a quarter of a millisecond. After the dwell it raises the VCO enable and the clock-output enable together.

From that point on, the power-good input and the select pins have no influence. Only a return of the supply-valid reset sends the block back to its off state. Logic downstream reads the held select code only while the clock-output enable is high.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the sequencer returns to the off state after that edge: `fsel_code` is 0, and `vco_en` and `clk_out_en` are 0. This holds from any state, including running.
- R2: `pg_n` is active low and passes through a two-flop synchronizer. The sequencer waits with the code at 0 and both enables low for as long as `pg_n` stays high. When `pg_n` falls, the code is still 0 after the second rising edge.
- R3: The enables rise exactly DWELL = CLK_KHZ*DELAY_US/1000 clock cycles after the sampling edge (minimum 1). The enables are still low after DWELL-1 cycles. The defaults give 25000 cycles at 100 MHz, which is 0.25 ms.
- R4: On the third rising edge after `pg_n` is driven low (the edge where waiting ends), `fsel_code[i]` takes `fsel_pins[i]`. The code then stays unchanged whatever the pins do, until the next reset.
- R5: `vco_en` and `clk_out_en` are both 0 in the off, waiting and sampling states, and both are 1 in the running state.
- R6: Once power-good has been seen, later changes on `pg_n` have no effect. This covers release during the dwell and toggling while running: the enables still rise on time and stay high, and the code stays unchanged.
- R7: The off state lasts one cycle after reset release. If `pg_n` is already low when reset is released, the select code is taken on the third rising edge after release. The enables rise DWELL cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Supply-valid, synchronous, active low |
| pg_n | input | 1 | Power-good, active low, asynchronous to clk |
| fsel_pins | input | 3 | Frequency-select pins |
| fsel_code | output | 3 | Held select code |
| vco_en | output | 1 | VCO enable |
| clk_out_en | output | 1 | Clock-output enable |

## Verification
The bench builds the block with CLK_KHZ set to 40 and DELAY_US set to 250, which gives a dwell of 10 cycles in place of 25000. This makes the exact cycle on which the enables rise cheap to check on both sides of the edge. It also lets many complete startups with different select codes, idle lengths and power-good patterns fit in a short run. The dwell length uses the same formula with the default values, so only the count itself changes.

// File: rtl/pwrup_pkg.sv
// Package: shared state encoding for the startup sequencer.
// Assumes: the numeric order of the states is the startup order 0..3.
package pwrup_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_t;

    localparam int SEL_W = 3;

endpackage

// File: rtl/pwrup_pg_sync.sv
// Module: brings the asynchronous active-low power-good input into the clock
// domain through a chain of flops and presents it as an active-high level.
// Assumes: STAGES >= 2; while in reset the output reads "not good".
module pwrup_pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_n_async,
    output logic pg_good
);

    logic [STAGES-1:0] chain_q;

    // Shift the inverted power-good level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], ~pg_n_async};
        end
    end

    assign pg_good = chain_q[STAGES-1];

endmodule

// File: rtl/pwrup_dwell.sv
// Module: counts the dwell between select sampling and clock enable.
// The count runs while 'active' is high and clears otherwise. 'expired'
// pulses in the last cycle of a DWELL-cycle window.
// Assumes: DWELL >= 1.
module pwrup_dwell #(
    parameter int DWELL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);

    localparam int CW   = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam int LAST = DWELL - 1;

    logic [CW-1:0] cnt_q;

    // Advance the dwell count during the sampling state, clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = active && (cnt_q == CW'(LAST));

    // R3: every dwell window starts from a cleared count.
    p_dwell_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (cnt_q == '0));

    // R3: the count never runs past the last cycle of the window.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (int'(cnt_q) <= LAST));

endmodule

// File: rtl/pwrup_sel_hold.sv
// Module: captures the frequency-select pins on a single load strobe and
// holds them until reset.
// Assumes: 'load' is high for one cycle per startup.
module pwrup_sel_hold #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] code
);

    logic [WIDTH-1:0] code_q;

    // Capture the pins on the load strobe, otherwise keep the held code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= pins;
        end
    end

    assign code = code_q;

    // R4: without a load the held code does not move.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(code_q));

endmodule

// File: rtl/pwrup_seq.sv
// Module: four-state startup sequencer for a clock generator
// (off, wait for power-good, sample and dwell, run).
// Assumes: rst_n is the supply-valid indication, synchronous to clk.
// CLK_KHZ is the clock frequency in kHz and DELAY_US is the dwell in
// microseconds; their product sets the dwell in cycles.
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int CLK_KHZ  = 100000,
    parameter int DELAY_US = 250,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pg_n,
    input  logic [SEL_W-1:0] fsel_pins,
    output logic [SEL_W-1:0] fsel_code,
    output logic             vco_en,
    output logic             clk_out_en
);

    localparam int DWELL_RAW = (CLK_KHZ * DELAY_US) / 1000;
    localparam int DWELL     = (DWELL_RAW < 1) ? 1 : DWELL_RAW;

    seq_state_t st_q, st_d;
    logic       pg_good;
    logic       dwell_done;
    logic       sel_load;

    pwrup_pg_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pg_n_async (pg_n),
        .pg_good    (pg_good)
    );

    pwrup_dwell #(.DWELL(DWELL)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (st_q == ST_SAMPLE),
        .expired (dwell_done)
    );

    pwrup_sel_hold #(.WIDTH(SEL_W)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sel_load),
        .pins  (fsel_pins),
        .code  (fsel_code)
    );

    // Next-state choice: power-good is looked at only in the waiting state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:    st_d = ST_WAIT;
            ST_WAIT:   if (pg_good) st_d = ST_SAMPLE;
            ST_SAMPLE: if (dwell_done) st_d = ST_RUN;
            ST_RUN:    st_d = ST_RUN;
            default:   st_d = ST_OFF;
        endcase
    end

    // State register; only supply-valid reset returns to off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_load   = (st_q == ST_WAIT) && pg_good;
    assign vco_en     = (st_q == ST_RUN);
    assign clk_out_en = (st_q == ST_RUN);

    // R7: the off state lasts a single cycle.
    p_off_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) |=> (st_q == ST_WAIT));

    // R2: without power-good the sequencer keeps waiting.
    p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && !pg_good) |=> (st_q == ST_WAIT));

    // R5: the enables only come up out of the sampling state.
    p_enable_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out_en) |-> ($past(st_q) == ST_SAMPLE));

    // R6: running is permanent until reset, whatever power-good does.
    p_run_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |=> (vco_en && clk_out_en));

    // R4: the code is frozen while sampling and running.
    p_code_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SAMPLE || st_q == ST_RUN) |=> $stable(fsel_code));

endmodule

// File: tb/tb_pwrup_seq.sv
module tb_pwrup_seq;

    localparam int CLK_KHZ  = 40;
    localparam int DELAY_US = 250;
    localparam int DWELL    = (CLK_KHZ * DELAY_US) / 1000;

    // Each vector: {select at sampling, select driven afterwards, idle cycles}
    localparam logic [10:0] VECS [0:5] = '{
        {3'd5, 3'd2, 5'd1},
        {3'd0, 3'd7, 5'd4},
        {3'd7, 3'd0, 5'd9},
        {3'd3, 3'd4, 5'd2},
        {3'd6, 3'd1, 5'd17},
        {3'd1, 3'd6, 5'd30}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pg_n;
    logic [2:0] fsel_pins;
    logic [2:0] fsel_code;
    logic       vco_en;
    logic       clk_out_en;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwrup_seq #(.CLK_KHZ(CLK_KHZ), .DELAY_US(DELAY_US)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pg_n       (pg_n),
        .fsel_pins  (fsel_pins),
        .fsel_code  (fsel_code),
        .vco_en     (vco_en),
        .clk_out_en (clk_out_en)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_en(input string req, input int exp);
        chk(req, int'(vco_en), exp);
        chk(req, int'(clk_out_en), exp);
    endtask

    task automatic do_reset(input logic [2:0] pins, input logic pg);
        rst_n = 1'b0;
        pg_n = pg;
        fsel_pins = pins;
        step(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        pg_n = 1'b1;
        fsel_pins = 3'd5;
        @(negedge clk);
        step(3);
        // R1: reset state
        chk("R1 reset code", int'(fsel_code), 0);
        chk_en("R1 reset enables", 0);

        for (int i = 0; i < 6; i++) begin
            logic [2:0] s_at;
            logic [2:0] s_late;
            int         idle;
            s_at = VECS[i][10:8];
            s_late = VECS[i][7:5];
            idle = int'(VECS[i][4:0]);
            do_reset(s_at, 1'b1);
            step(idle);
            // R2: waiting while power-good is inactive
            chk("R2 waiting code", int'(fsel_code), 0);
            chk_en("R2 waiting enables", 0);
            pg_n = 1'b0;
            step(2);
            // R2: two synchronizer flops still in flight
            chk("R2 sync lag code", int'(fsel_code), 0);
            step(1);
            // R4: code captured at the third edge
            chk("R4 captured code", int'(fsel_code), int'(s_at));
            fsel_pins = s_late;
            pg_n = 1'b1;  // R6: release during dwell
            step(DWELL - 1);
            chk_en("R3 before dwell end", 0);
            step(1);
            chk_en("R3 R5 enables at dwell end", 1);
            chk("R4 code held", int'(fsel_code), int'(s_at));
            pg_n = 1'b0;
            step(3);
            pg_n = 1'b1;
            step(4);
            // R6: power-good toggles while running
            chk_en("R6 enables after toggles", 1);
            chk("R6 code after toggles", int'(fsel_code), int'(s_at));
        end

        // R1: reset from the running state
        rst_n = 1'b0;
        step(1);
        chk("R1 reset from run code", int'(fsel_code), 0);
        chk_en("R1 reset from run enables", 0);

        // R7: power-good already low at reset release
        do_reset(3'd6, 1'b0);
        step(2);
        chk("R7 code before third edge", int'(fsel_code), 0);
        step(1);
        chk("R7 code at third edge", int'(fsel_code), 6);
        fsel_pins = 3'd3;
        step(DWELL - 1);
        chk_en("R7 enables before dwell end", 0);
        step(1);
        chk_en("R7 enables at dwell end", 1);
        chk("R7 code held", int'(fsel_code), 6);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule